// File: doc/BRIEF.md
# Ten-Source Edge/Level Interrupt Collector

This block gathers up to ten peripheral interrupt request lines and presents them to a host processor as a single active-low request. Each line first passes through a synchronizer. A per-source trigger mode then decides which activity counts as an event: a falling edge, a rising edge, either edge, a low level or a high level. Every event sets a sticky pending bit. The request output is driven low while at least one pending source is not masked.

The host uses a small word-wide register port. It reads pending bits and clears them, sets the mask, programs the trigger modes, drives a set of peripheral reset outputs and reads a fixed version word. The host detects the request on its falling edge. Software can force a new edge for events that are still pending by masking every source for one write and then restoring the previous mask.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the pending bits are 0, the mask reads 0xFFFF, both mode registers read 0, every peripheral reset output is 1 (released) and `irq_n` is 1.
- R2: Register addresses are: 0 pending, 1 mask, 2 mode-low, 3 mode-high, 4 peripheral reset, 5 version. Other addresses read 0. Source n < 5 takes its 3-bit mode from mode-low bits [3n+2:3n]. Source n ≥ 5 takes it from mode-high bits [3(n-5)+2:3(n-5)]. Bit 15 of both mode registers reads 0.
- R3: Mode 1 (falling) sets the pending bit on a 1→0 change of the synchronized input. The bit can be read on the third rising clock edge after the input changes.
- R4: Mode 2 (rising) sets the pending bit on a 0→1 change, and mode 3 sets it on either change.
- R5: Mode 4 (level low) and mode 5 (level high) set the pending bit on every cycle that the synchronized input is at the active level. A clear has no lasting effect while that level holds.
- R6: Modes 0, 6 and 7 never set a pending bit.
- R7: A write to the pending register clears each bit written as 0 and leaves each bit written as 1 unchanged. An event in the same cycle as a clear wins.
- R8: `irq_n` is registered. One cycle after a cycle in which some pending bit has a mask bit of 0 it is 0, and otherwise it is 1. A mask bit of 1 masks its source.
- R9: Writing 0xFFFF to the mask and then writing the earlier mask back drives `irq_n` high for one cycle and then low again, provided an unmasked bit is still pending.
- R10: The version register reads {board number, logic revision} in bits 15:8 and 7:0, and writes to it have no effect.
- R11: Bit i of the peripheral reset register drives `periph_rst_n[i]`. A 0 holds that peripheral in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_SRC | Asynchronous peripheral request lines |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| irq_n | output | 1 | Combined active-low request |
| periph_rst_n | output | NUM_PRST | Peripheral reset outputs, active low |

## Verification
The bench targets several corner cases.
- It clears pending bits while a level-mode input holds its level. A design that let the clear win would lose the bit and show a status of 0.
- It writes clear words with most bits set to 1. A design that cleared on 1, or wrote the word straight into the register, would wipe unrelated events.
- It runs the mask-all-then-restore sequence. If `irq_n` stayed low through the sequence, or came back late, the host would miss an edge.
- It exercises disabled and unused mode codes and writes to the read-only version word. A wrong mode decode or a stray register write shows up as a status or read-back mismatch on the cycle-by-cycle comparison.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
   localparam int MODE_W = 3;

   localparam logic [2:0] TRIG_OFF  = 3'd0;
   localparam logic [2:0] TRIG_FALL = 3'd1;
   localparam logic [2:0] TRIG_RISE = 3'd2;
   localparam logic [2:0] TRIG_BOTH = 3'd3;
   localparam logic [2:0] TRIG_LOW  = 3'd4;
   localparam logic [2:0] TRIG_HIGH = 3'd5;

   localparam logic [2:0] REG_STATUS  = 3'd0;
   localparam logic [2:0] REG_MASK    = 3'd1;
   localparam logic [2:0] REG_MODE_LO = 3'd2;
   localparam logic [2:0] REG_MODE_HI = 3'd3;
   localparam logic [2:0] REG_PRST    = 3'd4;
   localparam logic [2:0] REG_VERSION = 3'd5;
endpackage

// File: rtl/irq_agg_sync.sv
module irq_agg_sync #(
   parameter int WIDTH  = 10,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);
   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], async_in};
   end

   assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/irq_agg_detect.sv
module irq_agg_detect import irq_agg_pkg::*; #(
   parameter int NUM_SRC = 10
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_SRC-1:0]        level_in,
   input  logic [NUM_SRC*MODE_W-1:0] modes,
   output logic [NUM_SRC-1:0]        fire
);
   logic [NUM_SRC-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= level_in;
   end

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      logic [MODE_W-1:0] md;
      assign md = modes[i*MODE_W +: MODE_W];
      always_comb begin
         case (md)
            TRIG_FALL: fire[i] = prev_q[i] & ~level_in[i];
            TRIG_RISE: fire[i] = ~prev_q[i] & level_in[i];
            TRIG_BOTH: fire[i] = prev_q[i] ^ level_in[i];
            TRIG_LOW:  fire[i] = ~level_in[i];
            TRIG_HIGH: fire[i] = level_in[i];
            default:   fire[i] = 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator import irq_agg_pkg::*; #(
   parameter int          NUM_SRC     = 10,
   parameter int          DATA_W      = 16,
   parameter int          SRC_PER_REG = 5,
   parameter int          SYNC_STAGES = 2,
   parameter int          NUM_PRST    = 4,
   parameter logic [7:0]  BOARD_ID    = 8'h03,
   parameter logic [7:0]  LOGIC_REV   = 8'h11
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_SRC-1:0]  irq_in,
   input  logic                bus_wr,
   input  logic [2:0]          bus_addr,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   output logic                irq_n,
   output logic [NUM_PRST-1:0] periph_rst_n
);
   localparam int MODE_BITS = MODE_W * SRC_PER_REG;
   localparam logic [DATA_W-1:0] VERSION_WORD = DATA_W'({BOARD_ID, LOGIC_REV});

   if (NUM_SRC > DATA_W || NUM_SRC > 2 * SRC_PER_REG || NUM_SRC < 1) begin : g_bad_src
      $error("irq_aggregator: NUM_SRC does not fit the register layout");
   end
   if (MODE_BITS > DATA_W || DATA_W < 16) begin : g_bad_width
      $error("irq_aggregator: mode fields exceed the data width");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("irq_aggregator: at least two synchronizer stages required");
   end
   if (NUM_PRST < 1 || NUM_PRST > DATA_W) begin : g_bad_prst
      $error("irq_aggregator: NUM_PRST out of range");
   end

   logic [NUM_SRC-1:0]        pend_q;
   logic [DATA_W-1:0]         mask_q;
   logic [MODE_BITS-1:0]      mode_lo_q;
   logic [MODE_BITS-1:0]      mode_hi_q;
   logic [NUM_PRST-1:0]       prst_q;
   logic                      irq_n_q;
   logic [NUM_SRC-1:0]        src_sync;
   logic [NUM_SRC-1:0]        src_fire;
   logic [NUM_SRC*MODE_W-1:0] modes_flat;

   logic wr_status, wr_mask, wr_lo, wr_hi, wr_prst;
   assign wr_status = bus_wr && (bus_addr == REG_STATUS);
   assign wr_mask   = bus_wr && (bus_addr == REG_MASK);
   assign wr_lo     = bus_wr && (bus_addr == REG_MODE_LO);
   assign wr_hi     = bus_wr && (bus_addr == REG_MODE_HI);
   assign wr_prst   = bus_wr && (bus_addr == REG_PRST);

   // Mode field placement: fixed 3-bit lanes per source in two words
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_mode_map
      if (i < SRC_PER_REG) begin : g_lo
         assign modes_flat[i*MODE_W +: MODE_W] = mode_lo_q[i*MODE_W +: MODE_W];
      end else begin : g_hi
         assign modes_flat[i*MODE_W +: MODE_W] =
            mode_hi_q[(i-SRC_PER_REG)*MODE_W +: MODE_W];
      end
   end

   irq_agg_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) i_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (irq_in),
      .sync_out (src_sync)
   );

   irq_agg_detect #(.NUM_SRC(NUM_SRC)) i_detect (
      .clk      (clk),
      .rst_n    (rst_n),
      .level_in (src_sync),
      .modes    (modes_flat),
      .fire     (src_fire)
   );

   // Pending: write-zero-to-clear, a new event overrides a clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
      end else if (wr_status) begin
         pend_q <= (pend_q & bus_wdata[NUM_SRC-1:0]) | src_fire;
      end else begin
         pend_q <= pend_q | src_fire;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q    <= '1;
         mode_lo_q <= '0;
         mode_hi_q <= '0;
         prst_q    <= '1;
      end else begin
         if (wr_mask) mask_q    <= bus_wdata;
         if (wr_lo)   mode_lo_q <= bus_wdata[MODE_BITS-1:0];
         if (wr_hi)   mode_hi_q <= bus_wdata[MODE_BITS-1:0];
         if (wr_prst) prst_q    <= bus_wdata[NUM_PRST-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_n_q <= 1'b1;
      else        irq_n_q <= ~|(pend_q & ~mask_q[NUM_SRC-1:0]);
   end

   always_comb begin
      case (bus_addr)
         REG_STATUS:  bus_rdata = DATA_W'(pend_q);
         REG_MASK:    bus_rdata = mask_q;
         REG_MODE_LO: bus_rdata = DATA_W'(mode_lo_q);
         REG_MODE_HI: bus_rdata = DATA_W'(mode_hi_q);
         REG_PRST:    bus_rdata = DATA_W'(prst_q);
         REG_VERSION: bus_rdata = VERSION_WORD;
         default:     bus_rdata = '0;
      endcase
   end

   assign irq_n        = irq_n_q;
   assign periph_rst_n = prst_q;
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk import irq_agg_pkg::*; #(
   parameter int                NUM_SRC      = 10,
   parameter int                DATA_W       = 16,
   parameter int                NUM_PRST     = 4,
   parameter logic [DATA_W-1:0] VERSION_WORD = '0
) (
   input logic                clk,
   input logic                rst_n,
   input logic                bus_wr,
   input logic [2:0]          bus_addr,
   input logic [DATA_W-1:0]   bus_wdata,
   input logic [DATA_W-1:0]   bus_rdata,
   input logic                irq_n,
   input logic [NUM_PRST-1:0] periph_rst_n,
   input logic [NUM_SRC-1:0]  pend_q,
   input logic [DATA_W-1:0]   mask_q,
   input logic [NUM_SRC-1:0]  src_fire
);
   assert_set_needs_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend_q & ~$past(pend_q) & ~$past(src_fire)) == '0));

   assert_zero_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == REG_STATUS) |=>
      ((pend_q & ~$past(bus_wdata[NUM_SRC-1:0]) & ~$past(src_fire)) == '0));

   assert_one_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == REG_STATUS) |=>
      ((pend_q & $past(pend_q) & $past(bus_wdata[NUM_SRC-1:0])) ==
       ($past(pend_q) & $past(bus_wdata[NUM_SRC-1:0]))));

   assert_req_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (|(pend_q & ~mask_q[NUM_SRC-1:0])) |=> !irq_n);

   assert_req_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(pend_q & ~mask_q[NUM_SRC-1:0])) |=> irq_n);

   assert_mask_all_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == REG_MASK && bus_wdata == '1) |=> ##1 irq_n);

   assert_version_fixed_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == REG_VERSION) |-> (bus_rdata == VERSION_WORD));

   assert_prst_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == REG_PRST) |=>
      (periph_rst_n == $past(bus_wdata[NUM_PRST-1:0])));
endmodule

bind irq_aggregator irq_aggregator_chk #(
   .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .NUM_PRST(NUM_PRST), .VERSION_WORD(VERSION_WORD)
) i_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_n(irq_n),
   .periph_rst_n(periph_rst_n), .pend_q(pend_q), .mask_q(mask_q),
   .src_fire(src_fire)
);

// File: tb/test_irq_aggregator.sv
`timescale 1ns/1ps
module test_irq_aggregator;
   localparam int NSRC = 10;
   localparam int NPR  = 4;
   localparam logic [15:0] VER = 16'h0311;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NSRC-1:0] irq_in = '0;
   logic bus_wr = 1'b0;
   logic [2:0] bus_addr = 3'd0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic irq_n;
   logic [NPR-1:0] periph_rst_n;

   int checks = 0;
   int errors = 0;
   bit cmp_en = 1'b0;
   string cur_req = "R1";

   always #2 clk = ~clk;

   irq_aggregator i_irq_aggregator (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_n(irq_n), .periph_rst_n(periph_rst_n)
   );

   // Reference model state
   bit [NSRC-1:0] m_s1, m_s2, m_prev, m_pend;
   bit [15:0] m_mask;
   bit [14:0] m_lo, m_hi;
   bit [NPR-1:0] m_rst;
   bit m_irqn;

   function automatic bit fires(input int md, input bit now, input bit was);
      case (md)
         1: return was && !now;
         2: return !was && now;
         3: return was != now;
         4: return !now;
         5: return now;
         default: return 1'b0;
      endcase
   endfunction

   function automatic int mode_of(input int i);
      if (i < 5) return int'(m_lo[3*i +: 3]);
      return int'(m_hi[3*(i-5) +: 3]);
   endfunction

   function automatic logic [15:0] model_read(input logic [2:0] a);
      case (a)
         3'd0: return {6'd0, m_pend};
         3'd1: return m_mask;
         3'd2: return {1'b0, m_lo};
         3'd3: return {1'b0, m_hi};
         3'd4: return {12'd0, m_rst};
         3'd5: return VER;
         default: return 16'h0000;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_s1 = '0; m_s2 = '0; m_prev = '0; m_pend = '0;
         m_mask = 16'hFFFF; m_lo = '0; m_hi = '0; m_rst = '1; m_irqn = 1'b1;
      end else begin
         bit [NSRC-1:0] ev;
         bit [NSRC-1:0] np;
         for (int i = 0; i < NSRC; i++) ev[i] = fires(mode_of(i), m_s2[i], m_prev[i]);
         np = m_pend;
         if (bus_wr && bus_addr == 3'd0) np = np & bus_wdata[NSRC-1:0];
         np = np | ev;
         m_irqn = ((m_pend & ~m_mask[NSRC-1:0]) == '0);
         m_pend = np;
         if (bus_wr) begin
            case (bus_addr)
               3'd1: m_mask = bus_wdata;
               3'd2: m_lo = bus_wdata[14:0];
               3'd3: m_hi = bus_wdata[14:0];
               3'd4: m_rst = bus_wdata[NPR-1:0];
               default: ;
            endcase
         end
         m_prev = m_s2; m_s2 = m_s1; m_s1 = irq_in;
      end
   end

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (cmp_en) begin
         chk("R8", {15'd0, irq_n}, {15'd0, m_irqn});
         chk("R11", {12'd0, periph_rst_n}, {12'd0, m_rst});
         chk(cur_req, bus_rdata, model_read(bus_addr));
      end
   end

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin @(negedge clk); #1; end
   endtask

   task automatic rd(input string req, input logic [2:0] a, input logic [15:0] exp);
      bus_addr = a;
      @(negedge clk);
      chk(req, bus_rdata, exp);
      #1;
   endtask

   initial begin
      #(4 * 200000);
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] lfsr;
      repeat (3) @(posedge clk);
      @(negedge clk); #1;
      rst_n = 1'b1;
      @(posedge clk); cmp_en = 1'b1;
      @(negedge clk); #1;

      // R1 reset state
      cur_req = "R1";
      chk("R1", {15'd0, irq_n}, 16'h0001);
      chk("R1", {12'd0, periph_rst_n}, 16'h000F);
      rd("R1", 3'd0, 16'h0000);
      rd("R1", 3'd1, 16'hFFFF);
      rd("R1", 3'd2, 16'h0000);
      rd("R1", 3'd3, 16'h0000);

      // R2 mode layout: s0..s4 = 1,2,3,4,5 ; s5..s9 = 0,6,7,1,2
      cur_req = "R2";
      wr(3'd2, 16'hFFFF);
      rd("R2", 3'd2, 16'h7FFF);
      wr(3'd2, 16'h58D1);
      wr(3'd3, 16'h23F0);
      rd("R2", 3'd2, 16'h58D1);
      rd("R2", 3'd3, 16'h23F0);
      rd("R2", 3'd7, 16'h0000);

      // R5 level low on s3 while inputs low
      cur_req = "R5";
      wr(3'd1, 16'hFC00);
      idle(4);
      rd("R5", 3'd0, 16'h0008);
      wr(3'd0, 16'hFFF7);
      rd("R5", 3'd0, 16'h0008);

      // R4/R6 rising edges: s1 rise, s2 both, s9 rise, s4 high; s5..s7 silent
      cur_req = "R4";
      irq_in = '1;
      idle(5);
      rd("R4", 3'd0, 16'h021E);
      rd("R6", 3'd0, 16'h021E);
      cur_req = "R7";
      wr(3'd0, 16'h0000);
      rd("R7", 3'd0, 16'h0010);

      // R3 falling edges: s0 fall, s2 both, s8 fall, s3 low
      cur_req = "R3";
      irq_in = '0;
      idle(5);
      rd("R3", 3'd0, 16'h011D);
      cur_req = "R7";
      wr(3'd0, 16'hFFFE);
      rd("R7", 3'd0, 16'h011C);

      // R8 masking
      cur_req = "R8";
      wr(3'd1, 16'hFFFF);
      idle(2);
      chk("R8", {15'd0, irq_n}, 16'h0001);
      wr(3'd1, 16'hFEFF);
      idle(1);
      chk("R8", {15'd0, irq_n}, 16'h0000);

      // R9 mask all then restore gives one high cycle
      cur_req = "R9";
      wr(3'd1, 16'hFFFF);
      wr(3'd1, 16'hFEFF);
      chk("R9", {15'd0, irq_n}, 16'h0001);
      @(negedge clk);
      chk("R9", {15'd0, irq_n}, 16'h0000);
      #1;

      // Mixed traffic compared every cycle against the model
      cur_req = "R7";
      lfsr = 32'hACE1_1357;
      for (int c = 0; c < 600; c++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         if (lfsr[3:2] == 2'b00) irq_in = irq_in ^ lfsr[13:4];
         if (c % 7 == 3) wr(3'd0, lfsr[31:16]);
         else if (c % 29 == 5) wr(3'd1, {6'h3F, lfsr[25:16]});
         else if (c % 97 == 11) wr(3'd3, lfsr[30:16]);
         else idle(1);
      end

      // R10 version is read-only
      cur_req = "R10";
      wr(3'd5, 16'hFFFF);
      rd("R10", 3'd5, VER);

      // R11 peripheral resets
      cur_req = "R11";
      wr(3'd4, 16'h0005);
      chk("R11", {12'd0, periph_rst_n}, 16'h0005);
      wr(3'd4, 16'h000A);
      chk("R11", {12'd0, periph_rst_n}, 16'h000A);
      idle(2);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule